// File: doc/BRIEF.md
# Wait-State Memory Read Sequencer

This block is a small synchronous bus master that carries out single read transactions against a memory that is slower than the logic requesting the data. A client raises a request with an address. The sequencer accepts it only while it is idle. It then presents the address on its memory address output for one full cycle with the read strobe still inactive. Next it pulls the active-low read strobe down and keeps it down for a parameterised number of wait cycles so the memory has time to answer.

On the clock edge that releases the strobe, the sequencer samples the memory data bus into a result register. A single-cycle completion pulse accompanies the new result. While a transaction is in flight the ready output is low, and any request presented during that time is neither taken nor remembered. A read therefore always spans several clock cycles. Back-to-back reads are spaced by the wait count plus two cycles.

Top module: `memrd_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `mem_rd_n` is 1 and `rd_done` is 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `mem_addr` takes `req_addr` on that edge and keeps that value unchanged until the next taken request.
- R3: In the first cycle after a taken request the address is driven with `mem_rd_n` still 1. `mem_rd_n` falls exactly one cycle after the request edge, never while `req_ready` is 1.
- R4: Once low, `mem_rd_n` stays low for exactly `WAIT_CYCLES` consecutive cycles (default 1, minimum 1) and then returns to 1.
- R5: `rd_data` takes the value of `mem_data` sampled on the edge where `mem_rd_n` returns to 1. `rd_done` is 1 for exactly one cycle, the first cycle with the strobe high again. `rd_data` is unchanged outside that edge.
- R6: `req_ready` is 0 from the cycle after a taken request until `rd_done` rises, and is 1 in the `rd_done` cycle. Requests presented while it is 0 change neither `mem_addr` nor the returned data.
- R7: `rd_done` appears `WAIT_CYCLES`+1 cycles after the request edge. With the request held continuously, successive requests are taken `WAIT_CYCLES`+2 cycles apart.
- R8: Whenever `req_ready` is 1 the strobe `mem_rd_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client requests a read |
| req_addr | input | ADDR_W | Address of the requested read |
| req_ready | output | 1 | Sequencer idle; a request is taken this cycle if valid |
| rd_done | output | 1 | One-cycle pulse: `rd_data` holds a new result |
| rd_data | output | DATA_W | Last value captured from the memory |
| mem_addr | output | ADDR_W | Address presented to the memory |
| mem_rd_n | output | 1 | Read strobe to the memory, active low |
| mem_data | input | DATA_W | Data returned by the memory |

## Verification
A wrong phase register shows within one cycle of a taken request. Either the strobe falls in the same cycle as the address appears, or the ready output stays high while the strobe is low. A wait counter that loads or ends wrongly shows at the release edge as a strobe-low run that differs from `WAIT_CYCLES` and a completion pulse arriving early or late. A capture on the wrong edge returns the inverted value that the memory model drives while the strobe is high, so the first completed read reveals it.

// File: rtl/memrd_pkg.sv
package memrd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_STRB = 2'd2
  } memrd_state_e;

  // value loaded into the wait counter when the strobe falls
  function automatic int unsigned memrd_strobe_load(int unsigned wait_cycles);
    return (wait_cycles > 0) ? wait_cycles - 1 : 0;
  endfunction

  // width of a counter able to hold wait_cycles
  function automatic int unsigned memrd_cnt_width(int unsigned wait_cycles);
    return (wait_cycles < 2) ? 1 : $clog2(wait_cycles + 1);
  endfunction

endpackage

// File: rtl/memrd_fsm.sv
module memrd_fsm
  import memrd_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic accept,
  output logic capture,
  output logic req_ready,
  output logic mem_rd_n,
  output logic rd_done
);

  localparam int unsigned CW   = memrd_cnt_width(WAIT_CYCLES);
  localparam int unsigned LOAD = memrd_strobe_load(WAIT_CYCLES);

  memrd_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic          rd_n_q;
  logic          done_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign capture   = (state_q == ST_STRB) && (cnt_q == '0);
  assign mem_rd_n  = rd_n_q;
  assign rd_done   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rd_n_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= capture;
      unique case (state_q)
        ST_IDLE: if (accept) state_q <= ST_ADDR;
        ST_ADDR: begin
          state_q <= ST_STRB;
          cnt_q   <= CW'(LOAD);
          rd_n_q  <= 1'b0;
        end
        ST_STRB: begin
          if (capture) begin
            state_q <= ST_IDLE;
            rd_n_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // length of the current strobe-low run, for the R4 window check
  logic [CW-1:0] low_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) low_run_q <= '0;
    else        low_run_q <= mem_rd_n ? '0 : low_run_q + 1'b1;
  end

  a_r3_strobe_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd_n) |-> !$past(req_ready));

  a_r4_strobe_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_n) |-> (low_run_q == CW'(WAIT_CYCLES)));

  a_r5_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> $rose(mem_rd_n));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

  a_r8_idle_strobe_high: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> !req_ready);

endmodule

// File: rtl/memrd_datapath.sv
module memrd_datapath #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] mem_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (accept)  addr_q <= req_addr;
      if (capture) data_q <= mem_data;
    end
  end

  assign mem_addr = addr_q;
  assign rd_data  = data_q;

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(mem_addr));

  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rd_data));

  a_r6_no_double_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && capture));

endmodule

// File: rtl/memrd_seq.sv
module memrd_seq #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WAIT_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_n,
  input  logic [DATA_W-1:0] mem_data
);

  logic accept;
  logic capture;

  memrd_fsm #(
    .WAIT_CYCLES(WAIT_CYCLES)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .accept   (accept),
    .capture  (capture),
    .req_ready(req_ready),
    .mem_rd_n (mem_rd_n),
    .rd_done  (rd_done)
  );

  memrd_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .capture (capture),
    .req_addr(req_addr),
    .mem_data(mem_data),
    .mem_addr(mem_addr),
    .rd_data (rd_data)
  );

  a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

endmodule

// File: tb/memrd_seq_bench.sv
module memrd_seq_bench;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int W  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, rd_done, mem_rd_n;
  logic [DW-1:0] rd_data, mem_data;
  logic [AW-1:0] mem_addr;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit live = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  memrd_seq #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYCLES(W)) u_memrd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rd_done(rd_done), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_rd_n(mem_rd_n), .mem_data(mem_data));

  // memory model: true word while strobed, inverted word otherwise
  function automatic logic [DW-1:0] word_at(logic [AW-1:0] a);
    logic [DW-1:0] x;
    x = DW'(a) * 16'h9E37;
    return x ^ 16'h5A5A;
  endfunction
  assign mem_data = mem_rd_n ? ~word_at(mem_addr) : word_at(mem_addr);

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboard
  logic [DW-1:0] exp_q[$];
  int            acc_q[$];
  int            last_acc = -100;
  logic [AW-1:0] cur_addr = '0;

  task automatic issue(logic [AW-1:0] a, bit back_to_back);
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) @(negedge clk);
    if (back_to_back)
      check(cyc + 1 - last_acc == W + 2, "R7 period", cyc + 1 - last_acc, W + 2);
    exp_q.push_back(word_at(a));
    acc_q.push_back(cyc + 1);
    last_acc = cyc + 1;
    cur_addr = a;
    @(negedge clk);
  endtask

  task automatic release_req();
    req_valid = 1'b0;
    req_addr  = '0;
  endtask

  // monitor
  bit            prev_rd_n = 1;
  bit            prev_done = 0;
  int            low_run = 0;
  logic [DW-1:0] last_data = '0;
  always @(negedge clk) begin
    if (live) begin
      check(!(req_ready && !mem_rd_n), "R8", mem_rd_n, 1);
      if (!req_ready) check(mem_addr == cur_addr, "R2/R6 addr hold", mem_addr, cur_addr);
      if (prev_rd_n && !mem_rd_n) check(cyc == last_acc + 1, "R3 strobe fall", cyc - last_acc, 1);
      if (!mem_rd_n) low_run++;
      if (!prev_rd_n && mem_rd_n) begin
        check(low_run == W, "R4 strobe length", low_run, W);
        low_run = 0;
      end
      if (prev_done) check(!rd_done, "R5 single pulse", rd_done, 0);
      if (rd_done) begin
        check(exp_q.size() > 0, "R5 unexpected done", 0, 1);
        if (exp_q.size() > 0) begin
          logic [DW-1:0] e;
          int a;
          e = exp_q.pop_front();
          a = acc_q.pop_front();
          check(rd_data == e, "R5 data", rd_data, e);
          check(cyc - a == W + 1, "R7 latency", cyc - a, W + 1);
          check(!prev_rd_n && mem_rd_n, "R5 done on release", mem_rd_n, 1);
          check(req_ready, "R6 ready in done cycle", req_ready, 1);
          last_data = rd_data;
        end
      end else begin
        check(rd_data == last_data, "R5 data hold", rd_data, last_data);
      end
      prev_rd_n = mem_rd_n;
      prev_done = rd_done;
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1, "R1 ready", req_ready, 1);
    check(mem_rd_n == 1, "R1 strobe", mem_rd_n, 1);
    check(rd_done == 0, "R1 done", rd_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && mem_rd_n && !rd_done, "R1 after reset", {req_ready, mem_rd_n, rd_done}, 3'b110);
    live = 1;
    // idle, no request: nothing moves
    repeat (4) @(negedge clk);
    check(mem_rd_n && req_ready, "R2 no request", {req_ready, mem_rd_n}, 2'b11);
    // isolated reads
    issue(12'h123, 0); release_req();
    repeat (W + 4) @(negedge clk);
    issue(12'h000, 0); release_req();
    repeat (W + 4) @(negedge clk);
    issue(12'hFFF, 0); release_req();
    repeat (W + 4) @(negedge clk);
    // request held through busy: back-to-back with changing addresses (R6)
    issue(12'h0A5, 0);
    issue(12'h5A0, 1);
    issue(12'h777, 1);
    issue(12'h801, 1);
    release_req();
    // spurious request while busy is dropped before ready returns (R6)
    issue(12'h321, 0);
    req_valid = 1'b1;
    req_addr  = 12'hBAD;
    while (!req_ready) @(negedge clk);
    release_req();
    repeat (W + 6) @(negedge clk);
    check(mem_addr == 12'h321, "R6 ignored request", mem_addr, 12'h321);
    check(exp_q.size() == 0, "R7 all reads completed", exp_q.size(), 0);
    live = 0;
    finish_run();
  end
endmodule